// File: doc/BRIEF.md
# Multicycle Accumulator Core

A small multicycle processor core that reads its program one byte at a time from an external instruction memory. It has five W-bit general registers, a W-bit program counter, a carry flag and a zero flag. Every instruction starts with a two-byte instruction word. The first byte fetched becomes the high byte of that word. Some instructions are followed by a trailing W-bit word, which is also fetched high byte first.

The upper three bits of the instruction word choose the class: arithmetic, jump or memory. The next five bits hold the opcode. The low byte holds the destination register index in its upper nibble and the source register index in its lower nibble. Each arithmetic opcode has its own settings for result writeback, zero-flag update, carry-flag update and unary operation.

A debug port shows the program counter, the instruction word, all registers, both flags and a count of retired instructions. It is intended for observation and trace comparison.

Top module: `accum_core`

## Requirements
- R1: After reset the program counter, instruction word, all registers, both flags and the retired-instruction count are zero. Fetching starts at address 0.
- R2: An instruction word takes two cycles to fetch, from the addresses PC and PC+1, with the first byte as bits 15:8. Bits 15:13 are the class (000 arithmetic, 010 jump, 100 memory), bits 12:8 the opcode, bits 7:4 the destination and bits 3:0 the source. An instruction without a trailing word retires on its third clock edge. One with a trailing word retires on its fifth. Flags and registers change only at retirement.
- R3: Arithmetic opcode 0x00 adds, 0x01 subtracts (destination minus source) and 0x06 increments the destination (unary, source unused). All three write the result and update both flags. Carry is the bit above the result, which is the borrow for subtraction. Zero is set when the W-bit result is zero.
- R4: Arithmetic opcodes 0x02 AND, 0x03 OR and 0x04 XOR write the result and update zero only. Carry keeps its value.
- R5: Arithmetic opcode 0x05 compares. It updates zero and carry as a subtraction would, but leaves the registers unchanged. Opcode 0x07 copies the source into the destination and leaves both flags unchanged.
- R6: Jump opcodes 0x00 (always), 0x02 (zero set), 0x03 (zero clear), 0x04 (carry set) and 0x05 (carry clear) add the sign-extended low byte to the PC as it stands after the two-byte fetch. When the condition fails, the PC stays at the next instruction. Jumps never change registers or flags.
- R7: Jump opcode 0x0F loads the PC with the trailing word.
- R8: Memory opcode 0x01 writes the trailing word into the destination register. The PC then points past the trailing word.
- R9: A register index above 4 reads as zero, and writes to it are dropped.
- R10: The retired-instruction count rises by exactly one per retired instruction. Opcodes that are not defined retire with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | W | Byte address of the instruction memory (equal to PC) |
| imem_data | input | 8 | Byte read combinationally at imem_addr |
| dbg_pc | output | W | Program counter |
| dbg_ir | output | 16 | Current instruction word |
| dbg_regs | output | 5*W | Registers, register i at bits [i*W +: W] |
| dbg_cf | output | 1 | Carry flag |
| dbg_zf | output | 1 | Zero flag |
| dbg_icount | output | W | Retired-instruction count |

## Verification
Each instruction's effect is due a fixed number of rising edges after its first fetch edge: 3 for arithmetic and relative jumps, 5 for those carrying a trailing word. The bench adds up these counts for every program it places in memory. It samples on the falling edge after exactly that many rising edges. For the flag-retention program it also samples one edge earlier, to confirm that the earlier value is still held, so a result that is early or late is reported.

// File: rtl/accum_core.sv
module accum_core #(
  parameter int W    = 16,
  parameter int NREG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [W-1:0]      imem_addr,
  input  logic [7:0]        imem_data,
  output logic [W-1:0]      dbg_pc,
  output logic [15:0]       dbg_ir,
  output logic [NREG*W-1:0] dbg_regs,
  output logic              dbg_cf,
  output logic              dbg_zf,
  output logic [W-1:0]      dbg_icount
);
  typedef enum logic [2:0] {S_F0, S_F1, S_EX, S_W0, S_W1} st_t;

  st_t          st;
  logic [W-1:0] pc, icnt;
  logic [15:0]  ir;
  logic [7:0]   hold;
  logic         cf, zf;
  logic [W-1:0] rf [NREG];

  wire [2:0] cls = ir[15:13];
  wire [4:0] op  = ir[12:8];
  wire [3:0] di  = ir[7:4];
  wire [3:0] si  = ir[3:0];

  function automatic logic [W-1:0] rd(input logic [3:0] idx, input logic [W-1:0] f [NREG]);
    rd = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == 4'(i)) rd = f[i];
  endfunction

  wire [W-1:0] opa  = rd(di, rf);
  wire [W-1:0] opb  = rd(si, rf);
  wire [W-1:0] offs = {{(W-8){ir[7]}}, ir[7:0]};
  wire [W-1:0] word = {{(W-8){1'b0}}, hold} << 8 | {{(W-8){1'b0}}, imem_data};

  logic [W:0] res;
  logic       wb, uz, uc;

  always_comb begin
    res = '0; wb = 1'b0; uz = 1'b0; uc = 1'b0;
    case (op)
      5'h00: begin res = {1'b0, opa} + {1'b0, opb}; wb = 1'b1; uz = 1'b1; uc = 1'b1; end
      5'h01: begin res = {1'b0, opa} - {1'b0, opb}; wb = 1'b1; uz = 1'b1; uc = 1'b1; end
      5'h02: begin res = {1'b0, opa & opb}; wb = 1'b1; uz = 1'b1; end
      5'h03: begin res = {1'b0, opa | opb}; wb = 1'b1; uz = 1'b1; end
      5'h04: begin res = {1'b0, opa ^ opb}; wb = 1'b1; uz = 1'b1; end
      5'h05: begin res = {1'b0, opa} - {1'b0, opb}; uz = 1'b1; uc = 1'b1; end
      5'h06: begin res = {1'b0, opa} + 1'b1; wb = 1'b1; uz = 1'b1; uc = 1'b1; end
      5'h07: begin res = {1'b0, opb}; wb = 1'b1; end
      default: ;
    endcase
  end

  logic take;
  always_comb begin
    case (op)
      5'h00:   take = 1'b1;
      5'h02:   take = zf;
      5'h03:   take = !zf;
      5'h04:   take = cf;
      5'h05:   take = !cf;
      default: take = 1'b0;
    endcase
  end

  wire is_alu  = cls == 3'b000;
  wire is_jmp  = cls == 3'b010;
  wire is_mem  = cls == 3'b100;
  wire long_op = (is_jmp && op == 5'h0F) || (is_mem && op == 5'h01);

  wire         alu_we = st == S_EX && is_alu && wb;
  wire         ld_we  = st == S_W1 && is_mem;
  wire [W-1:0] wdata  = ld_we ? word : res[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_F0; pc <= '0; icnt <= '0; ir <= '0; hold <= '0;
      cf <= 1'b0; zf <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if ((alu_we || ld_we) && di == 4'(i)) rf[i] <= wdata;
      case (st)
        S_F0: begin ir[15:8] <= imem_data; pc <= pc + 1'b1; st <= S_F1; end
        S_F1: begin ir[7:0]  <= imem_data; pc <= pc + 1'b1; st <= S_EX; end
        S_EX: begin
          if (long_op) st <= S_W0;
          else begin
            st   <= S_F0;
            icnt <= icnt + 1'b1;
            if (is_alu) begin
              if (uz) zf <= res[W-1:0] == '0;
              if (uc) cf <= res[W];
            end
            if (is_jmp && take) pc <= pc + offs;
          end
        end
        S_W0: begin hold <= imem_data; pc <= pc + 1'b1; st <= S_W1; end
        S_W1: begin
          pc   <= is_jmp ? word : pc + 1'b1;
          icnt <= icnt + 1'b1;
          st   <= S_F0;
        end
        default: st <= S_F0;
      endcase
    end
  end

  assign imem_addr  = pc;
  assign dbg_pc     = pc;
  assign dbg_ir     = ir;
  assign dbg_cf     = cf;
  assign dbg_zf     = zf;
  assign dbg_icount = icnt;

  for (genvar g = 0; g < NREG; g++) begin : g_dbg
    assign dbg_regs[g*W +: W] = rf[g];
  end
endmodule

module accum_core_chk #(
  parameter int W    = 16,
  parameter int NREG = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      dbg_pc,
  input logic [15:0]       dbg_ir,
  input logic [NREG*W-1:0] dbg_regs,
  input logic              dbg_cf,
  input logic              dbg_zf,
  input logic [W-1:0]      dbg_icount
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dbg_pc == '0 && dbg_icount == '0 && dbg_regs == '0 && !dbg_cf && !dbg_zf));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_icount == $past(dbg_icount)) || (dbg_icount == W'($past(dbg_icount) + 1'b1)));

  a_r2_flags_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_icount == $past(dbg_icount)) |-> ($stable(dbg_cf) && $stable(dbg_zf)));

  a_r6_jump_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_icount != $past(dbg_icount) && dbg_ir[15:13] == 3'b010) |-> ($stable(dbg_regs) && $stable(dbg_cf) && $stable(dbg_zf)));

  a_r5_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_icount != $past(dbg_icount) && dbg_ir[15:8] == 8'h05) |-> $stable(dbg_regs));
endmodule

bind accum_core accum_core_chk #(.W(W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_regs(dbg_regs),
  .dbg_cf(dbg_cf), .dbg_zf(dbg_zf), .dbg_icount(dbg_icount)
);

// File: tb/accum_core_bench.sv
module accum_core_bench;
  localparam int W = 16;
  localparam int NREG = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] imem_addr, dbg_pc, dbg_icount;
  logic [7:0] imem_data;
  logic [15:0] dbg_ir;
  logic [NREG*W-1:0] dbg_regs;
  logic dbg_cf, dbg_zf;
  logic [7:0] mem [256];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign imem_data = mem[imem_addr[7:0]];

  accum_core u_accum_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_regs(dbg_regs), .dbg_cf(dbg_cf),
    .dbg_zf(dbg_zf), .dbg_icount(dbg_icount)
  );

  function automatic logic [15:0] reg_of(input int i);
    return dbg_regs[i*W +: W];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] b0, input logic [7:0] b1);
    mem[a] = b0; mem[a+1] = b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // op, a, b, expected r1, expected c, expected z
  localparam logic [54:0] VEC [10] = '{
    {5'h00, 16'h0001, 16'h0002, 16'h0003, 1'b0, 1'b0},
    {5'h00, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1},
    {5'h01, 16'h0005, 16'h0005, 16'h0000, 1'b0, 1'b1},
    {5'h01, 16'h0003, 16'h0005, 16'hFFFE, 1'b1, 1'b0},
    {5'h02, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0, 1'b0},
    {5'h03, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1},
    {5'h04, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b1},
    {5'h05, 16'h0003, 16'h0005, 16'h0003, 1'b1, 1'b0},
    {5'h06, 16'hFFFF, 16'h7777, 16'h0000, 1'b1, 1'b1},
    {5'h07, 16'h1111, 16'hBEEF, 16'hBEEF, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    do_reset();
    chk("R1 pc", dbg_pc, 0);
    chk("R1 ir", dbg_ir, 0);
    chk("R1 regs", 32'(dbg_regs != 0), 0);
    chk("R1 flags", {dbg_cf, dbg_zf}, 0);
    chk("R1 icount", dbg_icount, 0);

    // table walk: ld r1,a ; ld r2,b ; op r1,r2 ; jr -2
    for (int v = 0; v < 10; v++) begin
      logic [4:0] op; logic [15:0] a, b, er; logic ec, ez;
      {op, a, b, er, ec, ez} = VEC[v];
      clear_mem();
      put(0, 8'h81, 8'h10); put(2, a[15:8], a[7:0]);
      put(4, 8'h81, 8'h20); put(6, b[15:8], b[7:0]);
      put(8, {3'b000, op}, 8'h12);
      put(10, 8'h40, 8'hFE);
      do_reset();
      run(13);
      chk($sformatf("R3/R4/R5 vec%0d r1", v), reg_of(1), er);
      chk($sformatf("R3/R4/R5 vec%0d carry", v), dbg_cf, ec);
      chk($sformatf("R3/R4/R5 vec%0d zero", v), dbg_zf, ez);
      chk($sformatf("R8 vec%0d r2", v), reg_of(2), b);
    end

    // flag retention and timing
    clear_mem();
    put(0, 8'h81, 8'h10); put(2, 8'hFF, 8'hFF);
    put(4, 8'h81, 8'h20); put(6, 8'h00, 8'h01);
    put(8, 8'h00, 8'h12);
    put(10, 8'h81, 8'h10); put(12, 8'h00, 8'hF0);
    put(14, 8'h81, 8'h20); put(16, 8'h00, 8'h11);
    put(18, 8'h02, 8'h12);
    put(20, 8'h07, 8'h21);
    put(22, 8'h05, 8'h12);
    put(24, 8'h40, 8'hFE);
    do_reset();
    run(12);
    chk("R2 add not yet retired r1", reg_of(1), 16'hFFFF);
    chk("R2 add not yet retired c", dbg_cf, 0);
    run(1);
    chk("R3 add wrap r1", reg_of(1), 0);
    chk("R3 add wrap cz", {dbg_cf, dbg_zf}, 2'b11);
    run(13);
    chk("R4 and r1", reg_of(1), 16'h0010);
    chk("R4 and keeps carry, z", {dbg_cf, dbg_zf}, 2'b10);
    run(3);
    chk("R5 mov r2", reg_of(2), 16'h0010);
    chk("R5 mov keeps flags", {dbg_cf, dbg_zf}, 2'b10);
    run(3);
    chk("R5 cmp flags", {dbg_cf, dbg_zf}, 2'b01);
    chk("R5 cmp no write r1", reg_of(1), 16'h0010);
    chk("R10 icount", dbg_icount, 8);

    // jump program
    clear_mem();
    put(0, 8'h40, 8'h04);
    put(2, 8'h81, 8'h30); put(4, 8'hDE, 8'hAD);
    put(6, 8'h42, 8'h02);
    put(8, 8'h81, 8'h30); put(10, 8'h00, 8'h05);
    put(12, 8'h05, 8'h33);
    put(14, 8'h42, 8'h02);
    put(16, 8'h06, 8'h30);
    put(18, 8'h44, 8'h02);
    put(20, 8'h45, 8'h02);
    put(22, 8'h06, 8'h30);
    put(24, 8'h43, 8'h02);
    put(26, 8'h4F, 8'h00); put(28, 8'h00, 8'h20);
    put(30, 8'h06, 8'h30);
    put(32, 8'h81, 8'h40); put(34, 8'hAB, 8'hCD);
    put(36, 8'h81, 8'h70); put(38, 8'h11, 8'h11);
    put(40, 8'h06, 8'h70);
    put(42, 8'h03, 8'h47);
    put(44, 8'h40, 8'hFE);
    do_reset();
    run(3);
    chk("R6 jr taken pc", dbg_pc, 6);
    run(3);
    chk("R6 jrz not taken pc", dbg_pc, 8);
    run(41);
    chk("R6/R7 final pc", dbg_pc, 44);
    chk("R6 r3 skipped writes", reg_of(3), 5);
    chk("R8 r4 load", reg_of(4), 16'hABCD);
    chk("R9 other regs", {reg_of(0), reg_of(1)}, 0);
    chk("R9 high index flags", {dbg_cf, dbg_zf}, 2'b00);
    chk("R10 icount jumps", dbg_icount, 13);
    chk("R2 ir", dbg_ir, 16'h0347);
    run(3);
    chk("R6 backward jump pc", dbg_pc, 44);
    chk("R10 icount after loop", dbg_icount, 14);

    // undefined opcode
    clear_mem();
    put(0, 8'h81, 8'h10); put(2, 8'h00, 8'h07);
    put(4, 8'h1F, 8'h11);
    put(6, 8'h40, 8'hFE);
    do_reset();
    run(8);
    chk("R10 undefined op r1", reg_of(1), 7);
    chk("R10 undefined op pc", dbg_pc, 6);
    chk("R10 undefined op icount", dbg_icount, 2);

    do_reset();
    chk("R1 reset again regs", 32'(dbg_regs != 0), 0);
    chk("R1 reset again pc", dbg_pc, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule